// File: doc/BRIEF.md
# USB OUT Endpoint Handshake Controller

This block holds the buffer-ownership and stall state of seven bulk OUT endpoints, numbered 1 to 7. It sits between a USB serial engine and a local microcontroller. Each endpoint has two flags. The busy flag means the local buffer is armed and waiting for host data, so the CPU must not read it. The stall flag means the endpoint refuses all traffic. The CPU sees both flags through an 8-bit control/status register on a simple synchronous write bus with a combinational read port.

The CPU re-arms an endpoint by writing any value to that endpoint's byte-count address, which sets the busy flag. The serial engine pulses a transfer-complete strobe with the endpoint number, which clears the busy flag. When the busy flag falls, the endpoint's interrupt request is raised. The request stays pending until the CPU writes a one to that endpoint's bit in the interrupt-clear register.

For every OUT token the serial engine reports, the block returns a handshake one clock later, tagged with the endpoint number. A stalled endpoint answers STALL, a busy endpoint answers NAK, and any other endpoint answers ACK.

Top module: `usb_out_hs_ctrl`

## Requirements
- R1: The control/status register of endpoint n is read at address 0xC6 + 2·(n−1). Bit 1 is the busy flag, bit 0 is the stall flag, and bits 7..2 read as zero. After reset every flag reads zero.
- R2: A write to an endpoint's control/status address loads the stall flag from write-data bit 0. Write-data bit 1 has no effect on the busy flag.
- R3: A write of any data value to address 0x20 + 2·(n−1) sets endpoint n's busy flag from the next clock onward.
- R4: A transfer-complete strobe for endpoint n clears its busy flag from the next clock onward.
- R5: A token-valid pulse produces exactly one handshake-valid pulse one clock later, carrying the same endpoint number. The handshake code is computed from the flags as they stood at the token: STALL (2'b10) if the endpoint is stalled, otherwise NAK (2'b01) if it is busy, otherwise ACK (2'b00).
- R6: A token for endpoint 0 or for a number above 7 is answered with STALL (2'b10).
- R7: A 1-to-0 transition of endpoint n's busy flag sets interrupt output bit n−1 on the same clock edge. A transfer-complete strobe on an endpoint that is not busy raises nothing.
- R8: Writing data with bit n set to address 0x10 clears endpoint n's pending request. Bit 0 and zero bits have no effect. A busy fall in the same cycle as the clear leaves the request pending.
- R9: If a byte-count write and a transfer-complete strobe reach the same endpoint in one cycle, the busy flag ends set and no interrupt is raised.
- R10: Reads of any address that is not a control/status register return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 8 | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Combinational read data for cpu_addr |
| tok_valid | input | 1 | OUT token seen by the serial engine |
| tok_ep | input | 3 | Endpoint number of the token |
| xfer_done | input | 1 | OUT data packet stored completely |
| xfer_ep | input | 3 | Endpoint number of the completed transfer |
| hs_valid | output | 1 | Handshake decision valid |
| hs_ep | output | 3 | Endpoint number of the decision |
| hs_code | output | 2 | 00 ACK, 01 NAK, 10 STALL |
| irq | output | 7 | Pending request per endpoint, bit n−1 for endpoint n |

## Verification
The bench goes after four corner cases. The first is a byte-count write colliding with a transfer-complete strobe: a design that let the strobe win would drop the re-arm and raise a false interrupt. The second is an interrupt clear landing on the same cycle as a new busy fall: a design that let the clear win would lose an interrupt. The third is a token arriving on a busy and stalled endpoint: a design with the wrong priority would NAK or ACK. The fourth is a transfer-complete strobe to an idle endpoint, and bit 1 of a control/status write: a design that edge-detected loosely would raise a spurious request, and one that decoded loosely would let the CPU set the busy flag. A behavioural model that is compared every clock covers random traffic on all seven endpoints, endpoint 0, and unmapped addresses.

// File: rtl/usb_out_hs_pkg.sv
package usb_out_hs_pkg;

    typedef enum logic [1:0] {
        HS_ACK   = 2'b00,
        HS_NAK   = 2'b01,
        HS_STALL = 2'b10
    } hs_code_e;

    // Per-endpoint flag state
    typedef struct packed {
        logic busy;
        logic stall;
        logic irq;
    } ep_flags_t;

endpackage

// File: rtl/usb_out_hs_decode.sv
module usb_out_hs_decode #(
    parameter int              NUM_EP       = 7,
    parameter int              ADDR_W       = 8,
    parameter int              DATA_W       = 8,
    parameter logic [ADDR_W-1:0] CSR_BASE   = 8'hC6,
    parameter logic [ADDR_W-1:0] BC_BASE    = 8'h20,
    parameter logic [ADDR_W-1:0] IRQ_CLR_ADDR = 8'h10
) (
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [NUM_EP-1:0] csr_sel,
    output logic [NUM_EP-1:0] csr_wr,
    output logic [NUM_EP-1:0] bc_wr,
    output logic [NUM_EP-1:0] irq_clr
);

    logic clr_hit;
    assign clr_hit = cpu_wr && (cpu_addr == IRQ_CLR_ADDR);

    for (genvar i = 0; i < NUM_EP; i++) begin : g_dec
        localparam logic [ADDR_W-1:0] CSR_A = ADDR_W'(CSR_BASE + ADDR_W'(2 * i));
        localparam logic [ADDR_W-1:0] BC_A  = ADDR_W'(BC_BASE + ADDR_W'(2 * i));
        assign csr_sel[i] = (cpu_addr == CSR_A);
        assign csr_wr[i]  = cpu_wr && (cpu_addr == CSR_A);
        assign bc_wr[i]   = cpu_wr && (cpu_addr == BC_A);
        // Endpoint n owns clear bit n; bit 0 is unused
        assign irq_clr[i] = clr_hit && cpu_wdata[i + 1];
    end

endmodule

// File: rtl/usb_out_ep_flags.sv
module usb_out_ep_flags
    import usb_out_hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic csr_wr,
    input  logic stall_wdata,
    input  logic bc_wr,
    input  logic xfer_hit,
    input  logic irq_clr,
    output logic busy,
    output logic stall,
    output logic irq
);

    ep_flags_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Re-arm beats completion when both land together
        if (xfer_hit) st_d.busy = 1'b0;
        if (bc_wr)    st_d.busy = 1'b1;
        if (csr_wr)   st_d.stall = stall_wdata;
        // A new fall wins over a clear in the same cycle
        if (irq_clr)  st_d.irq = 1'b0;
        if (st_q.busy && !st_d.busy) st_d.irq = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy  = st_q.busy;
    assign stall = st_q.stall;
    assign irq   = st_q.irq;

endmodule

// File: rtl/usb_out_hs_select.sv
module usb_out_hs_select
    import usb_out_hs_pkg::*;
#(
    parameter int NUM_EP = 7,
    parameter int EP_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_valid,
    input  logic [EP_W-1:0]   tok_ep,
    input  logic [NUM_EP-1:0] busy_vec,
    input  logic [NUM_EP-1:0] stall_vec,
    output logic              hs_valid,
    output logic [EP_W-1:0]   hs_ep,
    output logic [1:0]        hs_code
);

    typedef struct packed {
        logic            valid;
        logic [EP_W-1:0] ep;
        hs_code_e        code;
    } hs_t;

    hs_t hs_d, hs_q;
    logic ep_known, sel_busy, sel_stall;

    always_comb begin
        ep_known  = 1'b0;
        sel_busy  = 1'b0;
        sel_stall = 1'b0;
        for (int i = 0; i < NUM_EP; i++) begin
            if (tok_ep == EP_W'(i + 1)) begin
                ep_known  = 1'b1;
                sel_busy  = busy_vec[i];
                sel_stall = stall_vec[i];
            end
        end
    end

    always_comb begin
        hs_d       = hs_q;
        hs_d.valid = tok_valid;
        if (tok_valid) begin
            hs_d.ep = tok_ep;
            if (!ep_known || sel_stall) hs_d.code = HS_STALL;
            else if (sel_busy)          hs_d.code = HS_NAK;
            else                        hs_d.code = HS_ACK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hs_q <= '{valid: 1'b0, ep: '0, code: HS_ACK};
        else        hs_q <= hs_d;
    end

    assign hs_valid = hs_q.valid;
    assign hs_ep    = hs_q.ep;
    assign hs_code  = hs_q.code;

endmodule

// File: rtl/usb_out_hs_ctrl.sv
module usb_out_hs_ctrl #(
    parameter int              NUM_EP       = 7,
    parameter int              EP_W         = 3,
    parameter int              ADDR_W       = 8,
    parameter int              DATA_W       = 8,
    parameter logic [ADDR_W-1:0] CSR_BASE   = 8'hC6,
    parameter logic [ADDR_W-1:0] BC_BASE    = 8'h20,
    parameter logic [ADDR_W-1:0] IRQ_CLR_ADDR = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              tok_valid,
    input  logic [EP_W-1:0]   tok_ep,
    input  logic              xfer_done,
    input  logic [EP_W-1:0]   xfer_ep,
    output logic              hs_valid,
    output logic [EP_W-1:0]   hs_ep,
    output logic [1:0]        hs_code,
    output logic [NUM_EP-1:0] irq
);

    logic [NUM_EP-1:0] csr_sel, csr_wr_vec, bc_wr_vec, irq_clr_vec;
    logic [NUM_EP-1:0] xfer_hit_vec, busy_vec, stall_vec;

    usb_out_hs_decode #(
        .NUM_EP(NUM_EP), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .CSR_BASE(CSR_BASE), .BC_BASE(BC_BASE), .IRQ_CLR_ADDR(IRQ_CLR_ADDR)
    ) u_dec (
        .cpu_wr   (cpu_wr),
        .cpu_addr (cpu_addr),
        .cpu_wdata(cpu_wdata),
        .csr_sel  (csr_sel),
        .csr_wr   (csr_wr_vec),
        .bc_wr    (bc_wr_vec),
        .irq_clr  (irq_clr_vec)
    );

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        assign xfer_hit_vec[i] = xfer_done && (xfer_ep == EP_W'(i + 1));
        usb_out_ep_flags u_flags (
            .clk        (clk),
            .rst_n      (rst_n),
            .csr_wr     (csr_wr_vec[i]),
            .stall_wdata(cpu_wdata[0]),
            .bc_wr      (bc_wr_vec[i]),
            .xfer_hit   (xfer_hit_vec[i]),
            .irq_clr    (irq_clr_vec[i]),
            .busy       (busy_vec[i]),
            .stall      (stall_vec[i]),
            .irq        (irq[i])
        );
    end

    usb_out_hs_select #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_hs (
        .clk      (clk),
        .rst_n    (rst_n),
        .tok_valid(tok_valid),
        .tok_ep   (tok_ep),
        .busy_vec (busy_vec),
        .stall_vec(stall_vec),
        .hs_valid (hs_valid),
        .hs_ep    (hs_ep),
        .hs_code  (hs_code)
    );

    // Read port: selected status byte, zero elsewhere
    always_comb begin
        cpu_rdata = '0;
        for (int i = 0; i < NUM_EP; i++) begin
            if (csr_sel[i]) cpu_rdata = DATA_W'({busy_vec[i], stall_vec[i]});
        end
    end

endmodule

// File: rtl/usb_out_hs_chk.sv
module usb_out_hs_chk #(
    parameter int NUM_EP = 7,
    parameter int EP_W   = 3,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tok_valid,
    input logic [EP_W-1:0]   tok_ep,
    input logic              hs_valid,
    input logic [EP_W-1:0]   hs_ep,
    input logic [1:0]        hs_code,
    input logic [NUM_EP-1:0] busy_vec,
    input logic [NUM_EP-1:0] stall_vec,
    input logic [NUM_EP-1:0] bc_wr_vec,
    input logic [NUM_EP-1:0] xfer_hit_vec,
    input logic [NUM_EP-1:0] irq,
    input logic [DATA_W-1:0] cpu_rdata
);

    logic [NUM_EP-1:0] tok_onehot;
    logic [NUM_EP-1:0] done_only;

    always_comb begin
        tok_onehot = '0;
        for (int i = 0; i < NUM_EP; i++)
            if (tok_ep == EP_W'(i + 1)) tok_onehot[i] = 1'b1;
    end
    assign done_only = xfer_hit_vec & ~bc_wr_vec;

    AST_HS_FOLLOWS_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid |=> hs_valid);  // R5
    AST_HS_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !tok_valid |=> !hs_valid);  // R5
    AST_HS_EP_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid |=> (hs_ep == $past(tok_ep)));  // R5
    AST_STALL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && ((stall_vec & tok_onehot) != '0)) |=> (hs_code == 2'b10));  // R5
    AST_UNKNOWN_EP_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && (tok_onehot == '0)) |=> (hs_code == 2'b10));  // R6
    AST_REARM_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_wr_vec != '0) |=> ((busy_vec & $past(bc_wr_vec)) == $past(bc_wr_vec)));  // R3
    AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_only != '0) |=> ((busy_vec & $past(done_only)) == '0));  // R4
    AST_FALL_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(busy_vec) & ~busy_vec & ~irq) == '0));  // R7
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rdata[DATA_W-1:2] == '0));  // R1

endmodule

bind usb_out_hs_ctrl usb_out_hs_chk #(
    .NUM_EP(NUM_EP), .EP_W(EP_W), .DATA_W(DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tok_valid   (tok_valid),
    .tok_ep      (tok_ep),
    .hs_valid    (hs_valid),
    .hs_ep       (hs_ep),
    .hs_code     (hs_code),
    .busy_vec    (busy_vec),
    .stall_vec   (stall_vec),
    .bc_wr_vec   (bc_wr_vec),
    .xfer_hit_vec(xfer_hit_vec),
    .irq         (irq),
    .cpu_rdata   (cpu_rdata)
);

// File: tb/usb_out_hs_ctrl_tb.sv
module usb_out_hs_ctrl_tb;

    localparam int NUM_EP = 7;
    localparam logic [7:0] CSR_BASE = 8'hC6;
    localparam logic [7:0] BC_BASE  = 8'h20;
    localparam logic [7:0] CLR_ADDR = 8'h10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_addr = 8'h00;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       tok_valid = 1'b0;
    logic [2:0] tok_ep = 3'd0;
    logic       xfer_done = 1'b0;
    logic [2:0] xfer_ep = 3'd0;
    logic       hs_valid;
    logic [2:0] hs_ep;
    logic [1:0] hs_code;
    logic [6:0] irq;

    always #5 clk = ~clk;

    usb_out_hs_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .tok_valid(tok_valid),
        .tok_ep(tok_ep), .xfer_done(xfer_done), .xfer_ep(xfer_ep),
        .hs_valid(hs_valid), .hs_ep(hs_ep), .hs_code(hs_code), .irq(irq)
    );

    int checks = 0;
    int fails  = 0;

    // Behavioural reference state, indexed by endpoint number
    bit       m_busy [1:7];
    bit       m_stall[1:7];
    bit       m_irq  [1:7];
    bit       e_hv = 1'b0;
    int       e_hc = 0;
    int       e_he = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int csr_ep(logic [7:0] a);
        for (int n = 1; n <= NUM_EP; n++)
            if (a == 8'(CSR_BASE + 8'(2 * (n - 1)))) return n;
        return 0;
    endfunction

    function automatic int bc_ep(logic [7:0] a);
        for (int n = 1; n <= NUM_EP; n++)
            if (a == 8'(BC_BASE + 8'(2 * (n - 1)))) return n;
        return 0;
    endfunction

    task automatic model_edge();
        bit nb;
        e_hv = tok_valid;
        if (tok_valid) begin
            e_he = int'(tok_ep);
            if (tok_ep == 0 || tok_ep > NUM_EP) e_hc = 2;
            else if (m_stall[tok_ep])           e_hc = 2;
            else if (m_busy[tok_ep])            e_hc = 1;
            else                                e_hc = 0;
        end
        for (int n = 1; n <= NUM_EP; n++) begin
            nb = m_busy[n];
            if (xfer_done && int'(xfer_ep) == n) nb = 1'b0;
            if (cpu_wr && bc_ep(cpu_addr) == n) nb = 1'b1;
            if (cpu_wr && csr_ep(cpu_addr) == n) m_stall[n] = cpu_wdata[0];
            if (cpu_wr && cpu_addr == CLR_ADDR && cpu_wdata[n]) m_irq[n] = 1'b0;
            if (m_busy[n] && !nb) m_irq[n] = 1'b1;
            m_busy[n] = nb;
        end
    endtask

    task automatic compare();
        int n;
        int exp_rd;
        chk(hs_valid == e_hv, "R5 hs_valid", int'(hs_valid), int'(e_hv));
        if (e_hv) begin
            chk(int'(hs_code) == e_hc, (e_he == 0) ? "R6 hs_code" : "R5 hs_code",
                int'(hs_code), e_hc);
            chk(int'(hs_ep) == e_he, "R5 hs_ep", int'(hs_ep), e_he);
        end
        for (int k = 1; k <= NUM_EP; k++)
            chk(irq[k-1] == m_irq[k], "R7/R8 irq", int'(irq), k);
        n = csr_ep(cpu_addr);
        exp_rd = (n != 0) ? {m_busy[n], m_stall[n]} : 0;
        chk(int'(cpu_rdata) == exp_rd, (n != 0) ? "R1 rdata" : "R10 rdata",
            int'(cpu_rdata), exp_rd);
    endtask

    task automatic step();
        @(posedge clk);
        if (rst_n) model_edge();
        #1;
        if (rst_n) compare();
    endtask

    task automatic idle();
        cpu_wr = 1'b0; tok_valid = 1'b0; xfer_done = 1'b0;
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        step();
        idle();
    endtask

    task automatic rd(int ep);
        cpu_addr = 8'(CSR_BASE + 8'(2 * (ep - 1)));
        #1;
    endtask

    task automatic token(int ep);
        tok_valid = 1'b1; tok_ep = 3'(ep);
        step();
        idle();
        step();
    endtask

    task automatic done(int ep);
        xfer_done = 1'b1; xfer_ep = 3'(ep);
        step();
        idle();
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int n = 1; n <= NUM_EP; n++) begin
            m_busy[n] = 0; m_stall[n] = 0; m_irq[n] = 0;
        end
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1: reset state of every status register and interrupt
        for (int n = 1; n <= NUM_EP; n++) begin
            rd(n);
            chk(cpu_rdata == 8'h00, "R1 reset csr", int'(cpu_rdata), 0);
        end
        chk(irq == 7'h00, "R1 reset irq", int'(irq), 0);

        // R5: idle endpoints ACK
        for (int n = 1; n <= NUM_EP; n++) token(n);

        // R3: re-arm ep3 with arbitrary data
        wr(8'(BC_BASE + 8'd4), 8'hA5);
        rd(3);
        chk(cpu_rdata == 8'h02, "R3 busy after rearm", int'(cpu_rdata), 2);
        token(3);  // R5 NAK

        // R2: status write sets stall, bit 1 ignored
        wr(8'(CSR_BASE + 8'd4), 8'hFF);
        rd(3);
        chk(cpu_rdata == 8'h03, "R2 stall set", int'(cpu_rdata), 3);
        token(3);  // R5 STALL beats NAK
        rd(5);
        wr(8'(CSR_BASE + 8'd8), 8'h02);
        rd(5);
        chk(cpu_rdata == 8'h00, "R2 busy not writable", int'(cpu_rdata), 0);
        wr(8'(CSR_BASE + 8'd4), 8'h00);

        // R4/R7: completion clears busy and raises irq
        done(3);
        rd(3);
        chk(cpu_rdata == 8'h00, "R4 busy cleared", int'(cpu_rdata), 0);
        chk(irq[2] == 1'b1, "R7 irq on fall", int'(irq), 4);
        token(3);

        // R7: completion on idle endpoint raises nothing
        done(6);
        chk(irq[5] == 1'b0, "R7 no irq when idle", int'(irq), 4);

        // R6: endpoint 0
        token(0);

        // R8: bit 0 clears nothing, bit 3 clears ep3
        wr(CLR_ADDR, 8'h01);
        chk(irq[2] == 1'b1, "R8 bit0 ignored", int'(irq), 4);
        wr(CLR_ADDR, 8'h08);
        chk(irq == 7'h00, "R8 clear", int'(irq), 0);

        // R8: clear and new fall together keep pending
        wr(8'(BC_BASE + 8'd2), 8'h00);
        cpu_wr = 1'b1; cpu_addr = CLR_ADDR; cpu_wdata = 8'h04;
        xfer_done = 1'b1; xfer_ep = 3'd2;
        step(); idle();
        chk(irq[1] == 1'b1, "R8 fall beats clear", int'(irq), 2);
        wr(CLR_ADDR, 8'hFE);

        // R9: rearm and completion collide
        cpu_wr = 1'b1; cpu_addr = 8'(BC_BASE + 8'd12); cpu_wdata = 8'h3C;
        xfer_done = 1'b1; xfer_ep = 3'd7;
        step(); idle();
        rd(7);
        chk(cpu_rdata == 8'h02, "R9 busy stays set", int'(cpu_rdata), 2);
        chk(irq[6] == 1'b0, "R9 no irq", int'(irq), 0);
        cpu_wr = 1'b1; cpu_addr = 8'(BC_BASE + 8'd12); cpu_wdata = 8'h00;
        xfer_done = 1'b1; xfer_ep = 3'd7;
        step(); idle();
        chk(irq[6] == 1'b0, "R9 no irq while busy", int'(irq), 0);

        // R10: unmapped read
        cpu_addr = 8'h55; #1;
        chk(cpu_rdata == 8'h00, "R10 unmapped", int'(cpu_rdata), 0);

        // Random traffic against the model
        for (int c = 0; c < 3000; c++) begin
            int kind;
            int ep;
            kind = int'($urandom_range(0, 9));
            ep   = int'($urandom_range(0, 7));
            cpu_wr    = 1'b0;
            tok_valid = ($urandom_range(0, 2) == 0);
            tok_ep    = 3'($urandom_range(0, 7));
            xfer_done = ($urandom_range(0, 3) == 0);
            xfer_ep   = 3'($urandom_range(0, 7));
            cpu_wdata = 8'($urandom);
            case (kind)
                0, 1: begin cpu_wr = 1'b1; cpu_addr = 8'(BC_BASE + 8'(2 * (ep % 7))); end
                2:    begin cpu_wr = 1'b1; cpu_addr = 8'(CSR_BASE + 8'(2 * (ep % 7)));
                            cpu_wdata[0] = ($urandom_range(0, 3) == 0); end
                3:    begin cpu_wr = 1'b1; cpu_addr = CLR_ADDR; end
                4:    cpu_addr = 8'($urandom);
                default: cpu_addr = 8'(CSR_BASE + 8'(2 * (ep % 7)));
            endcase
            step();
        end
        idle();
        step();
        summary();
    end

endmodule